// File: doc/BRIEF.md
# Chainable Periodic Interrupt Timer

This block holds a bank of down-counting periodic timers that share one count strobe. Each channel counts down from a programmed reload value, marks an expiry when a count step finds it at zero, reloads, and raises its own interrupt line when its flag is set and its interrupt is enabled. Software reaches every channel through a simple word-addressed read/write port.

A channel may be linked to the channel just below it. A linked channel steps only in the cycles where its predecessor expires, so two channels form one wide counter. The pair made of channels 0 and 1 can be read as a 64-bit lifetime value. Reading the upper word captures the lower channel's count, so the following lower-word read matches it.

A module control word can stop the whole bank, or stop it only while an external debug-halt input is high. Register writes are still accepted while the bank is stopped.

Top module: `chain_tick_timer`

## Requirements
- R1: After reset every load value, counter, control field, flag and the module control word is 0, and all interrupt outputs are low.
- R2: An enabled channel that is not linked takes one count step per cycle with `tick` high. A step that finds the counter above zero decrements it. A step that finds it at zero reloads the load value and sets the flag, so the channel expires once every load+1 steps.
- R3: A control write that sets bit 0 while the channel is off copies the load value into the counter at once. A load write on a running channel leaves the counter alone until the next reload.
- R4: Writing a word with bit 0 = 1 to a channel's flag register clears the flag. Writing bit 0 = 0 leaves it set.
- R5: `irq[n]` is high exactly when channel n's flag is set and bit 1 (interrupt enable) of its control register is 1.
- R6: With control bit 2 set, channel n > 0 steps only in cycles where channel n-1 expires. Channel 0 does not store bit 2: it always reads back 0 and channel 0 keeps counting on `tick`.
- R7: With module control bit 1 set, no counter changes and no flag gets set on any tick. Writes to load registers are still accepted and read back.
- R8: With module control bit 0 set, counters and flags hold while `dbg_halt` is high. Counting resumes normally once `dbg_halt` is low.
- R9: A read of address 0x0E0 returns channel 1's counter and captures channel 0's counter. A read of 0x0E4 returns the captured value, even if channel 0 has moved on since.
- R10: Address map: module control at 0x000. Channel n occupies 0x100+16n, with load at +0x0, counter at +0x4 (read-only, writes ignored), control at +0x8 and flag at +0xC. Any other address reads 0.
- R11: A channel whose enable bit is 0 keeps its counter value across ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count strobe, one step per cycle when high |
| dbg_halt | input | 1 | Debug halt request; stops counting if freeze is set |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (lifetime capture) |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 4 | One interrupt line per channel |

## Verification
The checker watches five properties on every cycle. While the bank is stopped or frozen, counters stay put and no new flag appears. A disabled channel holds its counter, and a set flag stays set unless a write occurs. Channel 0 reloads and flags correctly on every zero step, and a linked channel 1 stays still whenever channel 0 does not expire. Some behaviour only the bench scenarios can show: exact expiry periods for several load values, a load write that waits for the next reload, write-one-to-clear of the flags, the interrupt gating, the channel 0 link bit reading back 0, and the coherent capture of the lifetime pair.

// File: rtl/ctt_pkg.sv
package ctt_pkg;

   localparam int unsigned REG_MODCTL   = 'h000;
   localparam int unsigned REG_LIFE_HI  = 'h0E0;
   localparam int unsigned REG_LIFE_LO  = 'h0E4;
   localparam int unsigned CH_BASE      = 'h100;
   localparam int unsigned CH_STRIDE    = 16;

   typedef enum logic [1:0] {
      SEL_LOAD = 2'd0,
      SEL_CUR  = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_FLAG = 2'd3
   } ch_sel_e;

   typedef struct packed {
      logic chain;
      logic irq_en;
      logic run_en;
   } ch_ctrl_t;

   typedef struct packed {
      logic mod_off;
      logic freeze;
   } mod_ctrl_t;

endpackage

// File: rtl/ctt_decode.sv
module ctt_decode
   import ctt_pkg::*;
#(
   parameter int AW  = 12,
   parameter int NCH = 4,
   localparam int IW = $clog2(NCH)
) (
   input  logic [AW-1:0]  addr,
   input  logic           wr_en,
   input  logic           rd_en,
   output logic           hit_mod,
   output logic           hit_hi,
   output logic           hit_lo,
   output logic           hit_ch,
   output logic [IW-1:0]  ch_idx,
   output ch_sel_e        ch_sel,
   output logic           wr_mod,
   output logic           rd_hi,
   output logic [NCH-1:0] wr_load,
   output logic [NCH-1:0] wr_ctrl,
   output logic [NCH-1:0] wr_flag
);

   logic [AW-1:0] rel;

   assign rel     = addr - AW'(CH_BASE);
   assign hit_mod = (addr == AW'(REG_MODCTL));
   assign hit_hi  = (addr == AW'(REG_LIFE_HI));
   assign hit_lo  = (addr == AW'(REG_LIFE_LO));
   assign hit_ch  = (addr >= AW'(CH_BASE)) &&
                    (rel < AW'(NCH * CH_STRIDE)) &&
                    (addr[1:0] == 2'b00);
   assign ch_idx  = rel[4 +: IW];
   assign ch_sel  = ch_sel_e'(rel[3:2]);
   assign wr_mod  = wr_en && hit_mod;
   assign rd_hi   = rd_en && hit_hi;

   for (genvar n = 0; n < NCH; n++) begin : g_wdec
      logic mine;
      assign mine       = wr_en && hit_ch && (ch_idx == IW'(n));
      assign wr_load[n] = mine && (ch_sel == SEL_LOAD);
      assign wr_ctrl[n] = mine && (ch_sel == SEL_CTRL);
      assign wr_flag[n] = mine && (ch_sel == SEL_FLAG);
   end

endmodule

// File: rtl/ctt_channel.sv
module ctt_channel
   import ctt_pkg::*;
#(
   parameter int CW        = 32,
   parameter int DW        = 32,
   parameter bit CAN_CHAIN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_ok,
   input  logic          tick,
   input  logic          prev_exp,
   input  logic          wr_load,
   input  logic          wr_ctrl,
   input  logic          wr_flag,
   input  logic [DW-1:0] wdata,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] ld,
   output ch_ctrl_t      ctrl,
   output logic          flag,
   output logic          expire
);

   logic run_en_q;
   logic irq_en_q;
   logic chain_q;
   logic src;
   logic step;
   logic start;

   if (CAN_CHAIN) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       chain_q <= 1'b0;
         else if (wr_ctrl) chain_q <= wdata[2];
      end
      assign src = chain_q ? prev_exp : tick;
   end else begin : g_nochain
      assign chain_q = 1'b0;
      assign src     = tick;
   end

   assign step   = run_ok && run_en_q && src;
   assign expire = step && (cnt == '0);
   assign start  = wr_ctrl && wdata[0] && !run_en_q;
   assign ctrl   = '{chain: chain_q, irq_en: irq_en_q, run_en: run_en_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_en_q <= 1'b0;
         irq_en_q <= 1'b0;
      end else if (wr_ctrl) begin
         run_en_q <= wdata[0];
         irq_en_q <= wdata[1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ld <= '0;
      else if (wr_load) ld <= wdata[CW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (start)  cnt <= ld;
      else if (expire) cnt <= ld;
      else if (step)   cnt <= cnt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  flag <= 1'b0;
      else if (expire)             flag <= 1'b1;
      else if (wr_flag && wdata[0]) flag <= 1'b0;
   end

endmodule

// File: rtl/ctt_readmux.sv
module ctt_readmux
   import ctt_pkg::*;
#(
   parameter int CW  = 32,
   parameter int DW  = 32,
   parameter int NCH = 4,
   localparam int IW = $clog2(NCH)
) (
   input  logic                     hit_mod,
   input  logic                     hit_hi,
   input  logic                     hit_lo,
   input  logic                     hit_ch,
   input  logic [IW-1:0]            ch_idx,
   input  ch_sel_e                  ch_sel,
   input  mod_ctrl_t                modctl,
   input  logic [CW-1:0]            life_hi,
   input  logic [CW-1:0]            life_lo,
   input  logic [NCH-1:0][CW-1:0]   cnt_v,
   input  logic [NCH-1:0][CW-1:0]   ld_v,
   input  ch_ctrl_t [NCH-1:0]       ctrl_v,
   input  logic [NCH-1:0]           flg_v,
   output logic [DW-1:0]            rdata
);

   always_comb begin
      rdata = '0;
      if (hit_mod) begin
         rdata[1:0] = modctl;
      end else if (hit_hi) begin
         rdata[CW-1:0] = life_hi;
      end else if (hit_lo) begin
         rdata[CW-1:0] = life_lo;
      end else if (hit_ch) begin
         unique case (ch_sel)
            SEL_LOAD: rdata[CW-1:0] = ld_v[ch_idx];
            SEL_CUR:  rdata[CW-1:0] = cnt_v[ch_idx];
            SEL_CTRL: rdata[2:0]    = ctrl_v[ch_idx];
            SEL_FLAG: rdata[0]      = flg_v[ch_idx];
            default:  rdata         = '0;
         endcase
      end
   end

endmodule

// File: rtl/chain_tick_timer.sv
module chain_tick_timer
   import ctt_pkg::*;
#(
   parameter int NCH = 4,
   parameter int CW  = 32,
   parameter int DW  = 32,
   parameter int AW  = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic           dbg_halt,
   input  logic           wr_en,
   input  logic           rd_en,
   input  logic [AW-1:0]  addr,
   input  logic [DW-1:0]  wdata,
   output logic [DW-1:0]  rdata,
   output logic [NCH-1:0] irq
);

   localparam int IW    = $clog2(NCH);
   localparam int LT_LO = 0;
   localparam int LT_HI = 1;

   if (NCH < 2 || NCH > 16) begin : g_bad_nch
      $error("chain_tick_timer: NCH must lie in 2..16");
   end
   if (CW < 1 || CW > DW) begin : g_bad_cw
      $error("chain_tick_timer: CW must lie in 1..DW");
   end
   if (AW < 9) begin : g_bad_aw
      $error("chain_tick_timer: AW must be at least 9");
   end

   logic                   hit_mod, hit_hi, hit_lo, hit_ch;
   logic [IW-1:0]          ch_idx;
   ch_sel_e                ch_sel;
   logic                   wr_mod, rd_hi;
   logic [NCH-1:0]         wr_load, wr_ctrl, wr_flag;
   mod_ctrl_t              modctl;
   logic                   stopped;
   logic                   mod_frz;
   logic [NCH-1:0][CW-1:0] cnt_v, ld_v;
   ch_ctrl_t [NCH-1:0]     ctrl_v;
   logic [NCH-1:0]         flg_v, exp_v, en_v, ch_v, ie_v;
   logic [CW-1:0]          lo_snap;

   ctt_decode #(.AW(AW), .NCH(NCH)) u_dec (
      .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .hit_mod(hit_mod), .hit_hi(hit_hi), .hit_lo(hit_lo), .hit_ch(hit_ch),
      .ch_idx(ch_idx), .ch_sel(ch_sel), .wr_mod(wr_mod), .rd_hi(rd_hi),
      .wr_load(wr_load), .wr_ctrl(wr_ctrl), .wr_flag(wr_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      modctl <= '0;
      else if (wr_mod) modctl <= mod_ctrl_t'(wdata[1:0]);
   end

   assign mod_frz = modctl.freeze;
   assign stopped = modctl.mod_off || (modctl.freeze && dbg_halt);

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic pe;
      if (n == 0) begin : g_head
         assign pe = 1'b0;
      end else begin : g_link
         assign pe = exp_v[n-1];
      end

      ctt_channel #(.CW(CW), .DW(DW), .CAN_CHAIN(n > 0)) u_ch (
         .clk(clk), .rst_n(rst_n), .run_ok(!stopped), .tick(tick),
         .prev_exp(pe), .wr_load(wr_load[n]), .wr_ctrl(wr_ctrl[n]),
         .wr_flag(wr_flag[n]), .wdata(wdata),
         .cnt(cnt_v[n]), .ld(ld_v[n]), .ctrl(ctrl_v[n]),
         .flag(flg_v[n]), .expire(exp_v[n])
      );

      assign en_v[n] = ctrl_v[n].run_en;
      assign ch_v[n] = ctrl_v[n].chain;
      assign ie_v[n] = ctrl_v[n].irq_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lo_snap <= '0;
      else if (rd_hi) lo_snap <= cnt_v[LT_LO];
   end

   ctt_readmux #(.CW(CW), .DW(DW), .NCH(NCH)) u_rmux (
      .hit_mod(hit_mod), .hit_hi(hit_hi), .hit_lo(hit_lo), .hit_ch(hit_ch),
      .ch_idx(ch_idx), .ch_sel(ch_sel), .modctl(modctl),
      .life_hi(cnt_v[LT_HI]), .life_lo(lo_snap),
      .cnt_v(cnt_v), .ld_v(ld_v), .ctrl_v(ctrl_v), .flg_v(flg_v),
      .rdata(rdata)
   );

   assign irq = flg_v & ie_v;

endmodule

// File: rtl/ctt_checker.sv
module ctt_checker #(
   parameter int NCH = 4,
   parameter int CW  = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   tick,
   input logic                   wr_en,
   input logic                   dbg_halt,
   input logic                   mod_frz,
   input logic                   stopped,
   input logic [NCH-1:0][CW-1:0] cnt_v,
   input logic [NCH-1:0][CW-1:0] ld_v,
   input logic [NCH-1:0]         en_v,
   input logic [NCH-1:0]         ch_v,
   input logic [NCH-1:0]         flg_v
);

   logic head_exp;
   assign head_exp = tick && !stopped && en_v[0] && (cnt_v[0] == '0);

   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && !wr_en) |=> $stable(cnt_v)); // R7

   AST_STOP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |=> ((flg_v & ~$past(flg_v)) == '0)); // R7

   AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_frz && dbg_halt && !wr_en) |=> $stable(cnt_v)); // R8

   AST_HEAD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (head_exp && !wr_en) |=> ((cnt_v[0] == $past(ld_v[0])) && flg_v[0])); // R2

   AST_LINK_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_v[1] && !head_exp && !wr_en) |=> $stable(cnt_v[1])); // R6

   for (genvar i = 0; i < NCH; i++) begin : g_per
      AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (!en_v[i] && !wr_en) |=> $stable(cnt_v[i])); // R11

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flg_v[i] && !wr_en) |=> flg_v[i]); // R4
   end

endmodule

bind chain_tick_timer ctt_checker #(.NCH(NCH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
   .dbg_halt(dbg_halt), .mod_frz(mod_frz), .stopped(stopped),
   .cnt_v(cnt_v), .ld_v(ld_v), .en_v(en_v), .ch_v(ch_v), .flg_v(flg_v)
);

// File: tb/test_chain_tick_timer.sv
module test_chain_tick_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        dbg_halt = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  irq;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   chain_tick_timer i_chain_tick_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .dbg_halt(dbg_halt),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq(irq)
   );

   typedef struct packed {
      logic [31:0] ld;
      logic [7:0]  steps;
      logic [31:0] cnt;
      logic        flg;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{ld: 32'd5,  steps: 8'd3,  cnt: 32'd2,  flg: 1'b0},
      '{ld: 32'd5,  steps: 8'd5,  cnt: 32'd0,  flg: 1'b0},
      '{ld: 32'd5,  steps: 8'd6,  cnt: 32'd5,  flg: 1'b1},
      '{ld: 32'd5,  steps: 8'd8,  cnt: 32'd3,  flg: 1'b1},
      '{ld: 32'd0,  steps: 8'd1,  cnt: 32'd0,  flg: 1'b1},
      '{ld: 32'd1,  steps: 8'd2,  cnt: 32'd1,  flg: 1'b1},
      '{ld: 32'd3,  steps: 8'd0,  cnt: 32'd3,  flg: 1'b0},
      '{ld: 32'd10, steps: 8'd25, cnt: 32'd7,  flg: 1'b1}
   };

   function automatic logic [11:0] cha(input int n, input int off);
      return 12'(32'h100 + n * 16 + off);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         @(negedge clk);
         tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick = 1'b0; dbg_halt = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      do_reset();

      // R1: reset state
      rd(cha(0, 0), v);  chk("R1 load0",   v, 32'h0);
      rd(cha(3, 8), v);  chk("R1 ctrl3",   v, 32'h0);
      rd(12'h000, v);    chk("R1 modctl",  v, 32'h0);
      chk("R1 irq", {28'h0, irq}, 32'h0);

      // R2 table walk on channel 2, R11 hold after disable
      for (int k = 0; k < 8; k++) begin
         wr(cha(2, 0), VEC[k].ld);
         wr(cha(2, 8), 32'h1);
         ticks(int'(VEC[k].steps));
         rd(cha(2, 4), v);  chk("R2 count", v, VEC[k].cnt);
         rd(cha(2, 12), v); chk("R2 flag",  v, {31'h0, VEC[k].flg});
         wr(cha(2, 8), 32'h0);
         ticks(3);
         rd(cha(2, 4), v);  chk("R11 disabled hold", v, VEC[k].cnt);
         wr(cha(2, 12), 32'h1);
      end

      // R3: load write waits for reload
      do_reset();
      wr(cha(0, 0), 32'd4);
      wr(cha(0, 8), 32'h1);
      rd(cha(0, 4), v);  chk("R3 start load", v, 32'd4);
      ticks(2);
      wr(cha(0, 0), 32'd9);
      rd(cha(0, 4), v);  chk("R3 no early load", v, 32'd2);
      ticks(3);
      rd(cha(0, 4), v);  chk("R3 reload new", v, 32'd9);

      // R10: counter read-only, unmapped reads zero
      wr(cha(0, 4), 32'h55);
      rd(cha(0, 4), v);  chk("R10 counter read-only", v, 32'd9);
      rd(12'h040, v);    chk("R10 unmapped", v, 32'h0);
      rd(cha(0, 0), v);  chk("R10 load readback", v, 32'd9);

      // R4 / R5: flag clear and interrupt gating
      chk("R5 irq off while ie=0", {28'h0, irq}, 32'h0);
      wr(cha(0, 8), 32'h3);
      chk("R5 irq on", {28'h0, irq}, 32'h1);
      wr(cha(0, 12), 32'h0);
      rd(cha(0, 12), v); chk("R4 write zero keeps", v, 32'h1);
      wr(cha(0, 12), 32'h1);
      rd(cha(0, 12), v); chk("R4 write one clears", v, 32'h0);
      chk("R5 irq cleared", {28'h0, irq}, 32'h0);

      // R6 / R9: linked pair and lifetime read
      do_reset();
      wr(cha(0, 0), 32'd2);
      wr(cha(1, 0), 32'd5);
      wr(cha(1, 8), 32'h5);
      wr(cha(0, 8), 32'h5);
      rd(cha(0, 8), v);  chk("R6 chain bit ch0 reads 0", v, 32'h1);
      rd(cha(1, 8), v);  chk("R6 chain bit ch1 stored", v, 32'h5);
      ticks(7);
      rd(cha(0, 4), v);  chk("R6 head count", v, 32'd1);
      rd(12'h0E0, v);    chk("R9 upper word", v, 32'd3);
      ticks(1);
      rd(12'h0E4, v);    chk("R9 lower captured", v, 32'd1);
      rd(cha(0, 4), v);  chk("R6 head moved", v, 32'd0);
      rd(cha(1, 4), v);  chk("R6 link waits", v, 32'd3);

      // R7: module off
      do_reset();
      wr(cha(0, 0), 32'd3);
      wr(cha(0, 8), 32'h1);
      wr(12'h000, 32'h2);
      ticks(4);
      rd(cha(0, 4), v);  chk("R7 hold", v, 32'd3);
      rd(cha(0, 12), v); chk("R7 no flag", v, 32'h0);
      wr(cha(3, 0), 32'd7);
      rd(cha(3, 0), v);  chk("R7 write accepted", v, 32'd7);
      wr(12'h000, 32'h0);
      ticks(4);
      rd(cha(0, 4), v);  chk("R7 resumed", v, 32'd3);
      rd(cha(0, 12), v); chk("R7 flag after resume", v, 32'h1);

      // R8: freeze under debug halt
      wr(12'h000, 32'h1);
      dbg_halt = 1'b1;
      ticks(2);
      rd(cha(0, 4), v);  chk("R8 frozen", v, 32'd3);
      dbg_halt = 1'b0;
      ticks(1);
      rd(cha(0, 4), v);  chk("R8 thawed", v, 32'd2);

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule